// File: doc/BRIEF.md
# Stream-Tagged Instruction Line Fetcher

This block sits at the head of an in-order, single-thread pipeline front end. It holds the current fetch PC and produces one instruction-line request at a time. The request address is the PC rounded down to an instruction boundary. The request size runs from that address's offset within a snap granule up to the maximum line width. Once the downstream side accepts a request, the PC moves past the requested bytes. Address translation and the memory system are outside the block. They see only a valid/ready request port and a one-cycle completion pulse that may report a fault.

Two control inputs steer the fetcher. A redirect from the execute stage loads a new target PC and new stream and prediction tags. A branch prediction from the decode stage only takes effect if it was made for the current stream. A redirect in the same cycle always wins over a prediction. Every request carries the stream tag, the prediction tag and an incrementing line sequence number, so later stages can drop stale lines and keep flushes in order.

Issue stops in four cases: the number of outstanding fetches reaches a limit, a halt is held, a completed fetch has reported a fault, or no redirect has arrived since reset.

Top module: `line_fetcher`

## Requirements
- R1: After reset the fetcher waits for a target PC. `req_valid` stays low until the first accepted redirect, even with `req_ready` high.
- R2: A redirect seen while `halt` is low takes effect at the next clock edge. `req_addr` becomes `redir_pc` with its low log2(INSN_BYTES) bits cleared. `req_stream` and `req_pred` take `redir_stream` and `redir_pred`. `req_valid` rises.
- R3: `req_offset` equals `req_addr` modulo SNAP_BYTES, and `req_size` equals LINE_BYTES minus `req_offset`.
- R4: A request is issued when `req_valid` and `req_ready` are both high at a clock edge. If no redirect or prediction is accepted in that cycle, the next `req_addr` is the old `req_addr` plus the old `req_size`.
- R5: The outstanding count rises with each issued request and falls with each `rsp_valid` pulse. `req_valid` is low whenever this count equals MAX_INFLIGHT.
- R6: If a redirect and a prediction arrive in the same cycle, only the redirect takes effect.
- R7: A prediction is accepted only while running and only if `pred_stream` equals the current `req_stream`. It then sets `req_addr` to the aligned `pred_pc` and `req_pred` to `pred_pred`. A prediction with any other stream tag leaves the address and tags unchanged.
- R8: While `halt` is high, `req_valid` is low and redirects and predictions have no effect.
- R9: An `rsp_valid` pulse with `rsp_fault` high stops issue (`req_valid` low) until the next accepted redirect.
- R10: `req_lseq` starts at zero after reset and increases by one with each issued request, wrapping at its width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| halt | input | 1 | Holds the fetcher: blocks issue and ignores steering |
| redir_valid | input | 1 | Execute-stage stream change present |
| redir_pc | input | ADDR_W | Target PC of the stream change |
| redir_stream | input | SEQ_W | New stream tag |
| redir_pred | input | SEQ_W | New prediction tag |
| pred_valid | input | 1 | Decode-stage prediction present |
| pred_pc | input | ADDR_W | Predicted target PC |
| pred_stream | input | SEQ_W | Stream tag the prediction was made under |
| pred_pred | input | SEQ_W | New prediction tag |
| req_valid | output | 1 | Line request available |
| req_ready | input | 1 | Downstream accepts the request |
| req_addr | output | ADDR_W | Instruction-aligned start address |
| req_offset | output | log2(SNAP_BYTES) | Start offset within the snap granule |
| req_size | output | log2(LINE_BYTES+1) | Bytes requested |
| req_stream | output | SEQ_W | Stream tag of the request |
| req_pred | output | SEQ_W | Prediction tag of the request |
| req_lseq | output | LSEQ_W | Line sequence number |
| rsp_valid | input | 1 | One outstanding fetch completed |
| rsp_fault | input | 1 | The completed fetch faulted |

## Verification
The bench builds the fetcher with 12-bit addresses, 4-byte instructions, a 16-byte snap granule, a 32-byte line and a limit of two outstanding fetches. At that size every byte address from 0 to 63 can be used as a redirect target. The sweep therefore covers every instruction-alignment residue and every snap offset, including offset zero and the largest one. A limit of two lets the bench fill the outstanding count with two back-to-back issues, confirm that issue stops, and see issue resume after a completion. With 8-bit tags, the matching and mismatching predictions and the redirect-versus-prediction collision can each be set up with distinct values.

// File: rtl/lf_pkg.sv
// Shared definitions for the line fetcher.
// Assumes: nothing beyond a single fetch thread.
package lf_pkg;
    // Fetch sequencing state: waiting for a first target, or running.
    typedef enum logic {
        LF_WAIT_PC = 1'b0,
        LF_RUN     = 1'b1
    } lf_state_e;
endpackage

// File: rtl/lf_align.sv
// Combinational line geometry for the current fetch PC.
// Produces the instruction-aligned address, the offset inside the snap
// granule, the request size up to the line width, and the PC that
// follows the request.
// Assumes: INSN_BYTES and SNAP_BYTES are powers of two,
// SNAP_BYTES >= INSN_BYTES, LINE_BYTES >= SNAP_BYTES, and ADDR_W > SIZE_W.
module lf_align #(
    parameter int ADDR_W     = 32,
    parameter int INSN_BYTES = 4,
    parameter int SNAP_BYTES = 16,
    parameter int LINE_BYTES = 32,
    parameter int OFF_W      = 4,
    parameter int SIZE_W     = 6
) (
    input  logic [ADDR_W-1:0] pc,
    output logic [ADDR_W-1:0] aligned,
    output logic [OFF_W-1:0]  offset,
    output logic [SIZE_W-1:0] size,
    output logic [ADDR_W-1:0] next_pc
);
    localparam logic [ADDR_W-1:0] INSN_MASK = ~ADDR_W'(INSN_BYTES - 1);

    // Derive the aligned start, snap offset, byte count and follow-on PC.
    always_comb begin
        aligned = pc & INSN_MASK;
        offset  = aligned[OFF_W-1:0];
        size    = SIZE_W'(LINE_BYTES) - SIZE_W'(offset);
        next_pc = aligned + ADDR_W'(size);
    end
endmodule

// File: rtl/lf_credit.sv
// Outstanding-fetch counter.
// Counts issued requests that have not yet completed, and reports
// whether there is room for another one.
// Assumes: completions never outnumber issues. A completion seen at
// zero count is ignored.
module lf_credit #(
    parameter int MAX_INFLIGHT = 2,
    parameter int CNT_W        = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic take,
    input  logic give,
    output logic room
);
    logic [CNT_W-1:0] count_q;
    logic             dec;

    // A completion only counts down when something is outstanding.
    always_comb dec = give && (count_q != '0);

    // Track the number of fetches in flight.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (take && !dec) begin
            count_q <= count_q + CNT_W'(1);
        end else if (!take && dec) begin
            count_q <= count_q - CNT_W'(1);
        end
    end

    // Room is available below the configured limit.
    always_comb room = (count_q < CNT_W'(MAX_INFLIGHT));
endmodule

// File: rtl/lf_stream_ctl.sv
// Stream control for the line fetcher.
// Holds the fetch PC, the stream and prediction tags, the line sequence
// counter, the fault stop and the wait/run state. It arbitrates between
// the execute redirect (highest priority), the decode prediction, and
// the normal advance after an issued request.
// Assumes: `issue` is only asserted when `can_fetch` is high and halt is low.
module lf_stream_ctl
    import lf_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SEQ_W  = 8,
    parameter int LSEQ_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              halt,
    input  logic              redir_valid,
    input  logic [ADDR_W-1:0] redir_pc,
    input  logic [SEQ_W-1:0]  redir_stream,
    input  logic [SEQ_W-1:0]  redir_pred,
    input  logic              pred_valid,
    input  logic [ADDR_W-1:0] pred_pc,
    input  logic [SEQ_W-1:0]  pred_stream,
    input  logic [SEQ_W-1:0]  pred_pred,
    input  logic              issue,
    input  logic              rsp_valid,
    input  logic              rsp_fault,
    input  logic [ADDR_W-1:0] next_pc,
    output logic [ADDR_W-1:0] pc,
    output logic [SEQ_W-1:0]  stream,
    output logic [SEQ_W-1:0]  pred,
    output logic [LSEQ_W-1:0] lseq,
    output logic              can_fetch
);
    lf_state_e         state_q;
    logic              fault_q;
    logic [ADDR_W-1:0] pc_q;
    logic [SEQ_W-1:0]  stream_q;
    logic [SEQ_W-1:0]  pred_q;
    logic [LSEQ_W-1:0] lseq_q;
    logic              take_redir;
    logic              take_pred;

    // Decide which steering input, if any, is adopted this cycle.
    always_comb begin
        take_redir = redir_valid && !halt;
        take_pred  = pred_valid && !halt && !redir_valid &&
                     (state_q == LF_RUN) && (pred_stream == stream_q);
    end

    // Wait/run state: the first accepted redirect starts fetching.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LF_WAIT_PC;
        end else if (take_redir) begin
            state_q <= LF_RUN;
        end
    end

    // Fetch PC: redirect, then prediction, then sequential advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= '0;
        end else if (take_redir) begin
            pc_q <= redir_pc;
        end else if (take_pred) begin
            pc_q <= pred_pc;
        end else if (issue) begin
            pc_q <= next_pc;
        end
    end

    // Stream and prediction tags follow the accepted steering input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stream_q <= '0;
            pred_q   <= '0;
        end else if (take_redir) begin
            stream_q <= redir_stream;
            pred_q   <= redir_pred;
        end else if (take_pred) begin
            pred_q   <= pred_pred;
        end
    end

    // Fault stop: set by a faulting completion, cleared by a redirect.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_q <= 1'b0;
        end else if (take_redir) begin
            fault_q <= 1'b0;
        end else if (rsp_valid && rsp_fault) begin
            fault_q <= 1'b1;
        end
    end

    // Line sequence number advances once per issued request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lseq_q <= '0;
        end else if (issue) begin
            lseq_q <= lseq_q + LSEQ_W'(1);
        end
    end

    // Expose the held state.
    always_comb begin
        pc        = pc_q;
        stream    = stream_q;
        pred      = pred_q;
        lseq      = lseq_q;
        can_fetch = (state_q == LF_RUN) && !fault_q;
    end
endmodule

// File: rtl/line_fetcher.sv
// Stream-tagged instruction line fetcher, top level.
// Joins the stream controller, the line geometry and the outstanding
// counter, and drives a valid/ready request port.
// Assumes: rsp_valid pulses once per completed request, and the geometry
// parameters satisfy the constraints listed in lf_align.
module line_fetcher #(
    parameter int ADDR_W       = 32,
    parameter int INSN_BYTES   = 4,
    parameter int SNAP_BYTES   = 16,
    parameter int LINE_BYTES   = 32,
    parameter int MAX_INFLIGHT = 2,
    parameter int SEQ_W        = 8,
    parameter int LSEQ_W       = 8,
    localparam int OFF_W       = $clog2(SNAP_BYTES),
    localparam int SIZE_W      = $clog2(LINE_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              halt,
    input  logic              redir_valid,
    input  logic [ADDR_W-1:0] redir_pc,
    input  logic [SEQ_W-1:0]  redir_stream,
    input  logic [SEQ_W-1:0]  redir_pred,
    input  logic              pred_valid,
    input  logic [ADDR_W-1:0] pred_pc,
    input  logic [SEQ_W-1:0]  pred_stream,
    input  logic [SEQ_W-1:0]  pred_pred,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [ADDR_W-1:0] req_addr,
    output logic [OFF_W-1:0]  req_offset,
    output logic [SIZE_W-1:0] req_size,
    output logic [SEQ_W-1:0]  req_stream,
    output logic [SEQ_W-1:0]  req_pred,
    output logic [LSEQ_W-1:0] req_lseq,
    input  logic              rsp_valid,
    input  logic              rsp_fault
);
    localparam int CNT_W = $clog2(MAX_INFLIGHT + 1);

    logic [ADDR_W-1:0] pc;
    logic [ADDR_W-1:0] next_pc;
    logic              can_fetch;
    logic              room;
    logic              issue;

    // Request handshake: offered when running, fault-free, unhalted, with room.
    always_comb begin
        req_valid = can_fetch && !halt && room;
        issue     = req_valid && req_ready;
    end

    lf_stream_ctl #(
        .ADDR_W (ADDR_W),
        .SEQ_W  (SEQ_W),
        .LSEQ_W (LSEQ_W)
    ) u_ctl (
        .clk          (clk),
        .rst_n        (rst_n),
        .halt         (halt),
        .redir_valid  (redir_valid),
        .redir_pc     (redir_pc),
        .redir_stream (redir_stream),
        .redir_pred   (redir_pred),
        .pred_valid   (pred_valid),
        .pred_pc      (pred_pc),
        .pred_stream  (pred_stream),
        .pred_pred    (pred_pred),
        .issue        (issue),
        .rsp_valid    (rsp_valid),
        .rsp_fault    (rsp_fault),
        .next_pc      (next_pc),
        .pc           (pc),
        .stream       (req_stream),
        .pred         (req_pred),
        .lseq         (req_lseq),
        .can_fetch    (can_fetch)
    );

    lf_align #(
        .ADDR_W     (ADDR_W),
        .INSN_BYTES (INSN_BYTES),
        .SNAP_BYTES (SNAP_BYTES),
        .LINE_BYTES (LINE_BYTES),
        .OFF_W      (OFF_W),
        .SIZE_W     (SIZE_W)
    ) u_align (
        .pc      (pc),
        .aligned (req_addr),
        .offset  (req_offset),
        .size    (req_size),
        .next_pc (next_pc)
    );

    lf_credit #(
        .MAX_INFLIGHT (MAX_INFLIGHT),
        .CNT_W        (CNT_W)
    ) u_credit (
        .clk   (clk),
        .rst_n (rst_n),
        .take  (issue),
        .give  (rsp_valid),
        .room  (room)
    );
endmodule

// File: rtl/lf_checker.sv
// Property checker for line_fetcher, attached by bind.
// Keeps its own count of outstanding fetches from the port handshakes.
module lf_checker #(
    parameter int ADDR_W       = 32,
    parameter int SNAP_BYTES   = 16,
    parameter int LINE_BYTES   = 32,
    parameter int MAX_INFLIGHT = 2,
    parameter int LSEQ_W       = 8,
    localparam int OFF_W       = $clog2(SNAP_BYTES),
    localparam int SIZE_W      = $clog2(LINE_BYTES + 1),
    localparam int CNT_W       = $clog2(MAX_INFLIGHT + 1) + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              halt,
    input logic              redir_valid,
    input logic              pred_valid,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_addr,
    input logic [OFF_W-1:0]  req_offset,
    input logic [SIZE_W-1:0] req_size,
    input logic [LSEQ_W-1:0] req_lseq,
    input logic              rsp_valid,
    input logic              rsp_fault
);
    logic [CNT_W-1:0]  outstanding;
    logic              fire;
    logic [ADDR_W-1:0] follow_addr;

    // Port-level view of an issue and the address that should follow it.
    always_comb begin
        fire        = req_valid && req_ready;
        follow_addr = req_addr + ADDR_W'(req_size);
    end

    // Independent outstanding-fetch count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            outstanding <= '0;
        end else if (fire && !(rsp_valid && outstanding != '0)) begin
            outstanding <= outstanding + CNT_W'(1);
        end else if (!fire && rsp_valid && outstanding != '0) begin
            outstanding <= outstanding - CNT_W'(1);
        end
    end

    // R1: nothing is offered in the first cycle after reset.
    a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> !req_valid);

    // R3: offset and size together fill the line.
    a_r3_fill_line: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (SIZE_W'(req_offset) + req_size) == SIZE_W'(LINE_BYTES));

    // R4: an unsteered issue moves the address past the requested bytes.
    a_r4_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !redir_valid && !pred_valid) |=> req_addr == $past(follow_addr));

    // R5: never offered with the limit already outstanding.
    a_r5_limit: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> outstanding < CNT_W'(MAX_INFLIGHT));

    // R8: halt blocks issue.
    a_r8_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        halt |-> !req_valid);

    // R9: a faulting completion without a redirect stops issue.
    a_r9_fault_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault && !redir_valid) |=> !req_valid);

    // R10: line sequence steps by one per issue.
    a_r10_lseq_step: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> req_lseq == $past(req_lseq) + LSEQ_W'(1));
endmodule

bind line_fetcher lf_checker #(
    .ADDR_W       (ADDR_W),
    .SNAP_BYTES   (SNAP_BYTES),
    .LINE_BYTES   (LINE_BYTES),
    .MAX_INFLIGHT (MAX_INFLIGHT),
    .LSEQ_W       (LSEQ_W)
) u_lf_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .halt        (halt),
    .redir_valid (redir_valid),
    .pred_valid  (pred_valid),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_addr    (req_addr),
    .req_offset  (req_offset),
    .req_size    (req_size),
    .req_lseq    (req_lseq),
    .rsp_valid   (rsp_valid),
    .rsp_fault   (rsp_fault)
);

// File: tb/line_fetcher_test.sv
// Self-checking bench for line_fetcher in a small configuration.
module line_fetcher_test;
    localparam int AW = 12;
    localparam int SW = 8;
    localparam int LW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          halt = 1'b0;
    logic          redir_valid = 1'b0;
    logic [AW-1:0] redir_pc = '0;
    logic [SW-1:0] redir_stream = '0;
    logic [SW-1:0] redir_pred = '0;
    logic          pred_valid = 1'b0;
    logic [AW-1:0] pred_pc = '0;
    logic [SW-1:0] pred_stream = '0;
    logic [SW-1:0] pred_pred = '0;
    logic          req_valid;
    logic          req_ready = 1'b0;
    logic [AW-1:0] req_addr;
    logic [3:0]    req_offset;
    logic [5:0]    req_size;
    logic [SW-1:0] req_stream;
    logic [SW-1:0] req_pred;
    logic [LW-1:0] req_lseq;
    logic          rsp_valid = 1'b0;
    logic          rsp_fault = 1'b0;

    int checks = 0;
    int errors = 0;
    int exp_lseq = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    line_fetcher #(
        .ADDR_W(AW), .INSN_BYTES(4), .SNAP_BYTES(16), .LINE_BYTES(32),
        .MAX_INFLIGHT(2), .SEQ_W(SW), .LSEQ_W(LW)
    ) uut (
        .clk(clk), .rst_n(rst_n), .halt(halt),
        .redir_valid(redir_valid), .redir_pc(redir_pc),
        .redir_stream(redir_stream), .redir_pred(redir_pred),
        .pred_valid(pred_valid), .pred_pc(pred_pc),
        .pred_stream(pred_stream), .pred_pred(pred_pred),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_offset(req_offset), .req_size(req_size),
        .req_stream(req_stream), .req_pred(req_pred), .req_lseq(req_lseq),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            finish_run();
        end
    end

    initial begin
        @(negedge clk);
        req_ready = 1'b1;
        repeat (3) step();
        chk("R1 reset", int'(req_valid), 0);
        rst_n = 1'b1;
        step();
        chk("R1 wait for pc", int'(req_valid), 0);
        req_ready = 1'b0;

        // R2 R3 R4 R10: sweep every byte address 0..63 as a redirect target
        for (int p = 0; p < 64; p++) begin
            int al;
            int off;
            int sz;
            al  = p & ~3;
            off = al % 16;
            sz  = 32 - off;
            redir_valid  = 1'b1;
            redir_pc     = AW'(p);
            redir_stream = SW'(p);
            redir_pred   = SW'(p * 3 + 1);
            step();
            redir_valid = 1'b0;
            chk("R2 valid", int'(req_valid), 1);
            chk("R2 addr", int'(req_addr), al);
            chk("R2 stream", int'(req_stream), p);
            chk("R2 pred", int'(req_pred), (p * 3 + 1) & 255);
            chk("R3 offset", int'(req_offset), off);
            chk("R3 size", int'(req_size), sz);
            chk("R10 lseq", int'(req_lseq), exp_lseq & 255);
            req_ready = 1'b1;
            step();
            req_ready = 1'b0;
            exp_lseq++;
            chk("R4 advance", int'(req_addr), al + sz);
            chk("R10 lseq step", int'(req_lseq), exp_lseq & 255);
            rsp_valid = 1'b1;
            step();
            rsp_valid = 1'b0;
        end

        // Known start for the directed cases
        redir_valid = 1'b1; redir_pc = 12'h100; redir_stream = 8'h20; redir_pred = 8'h05;
        step();
        redir_valid = 1'b0;

        // R5: two issues fill the limit
        req_ready = 1'b1;
        step();
        exp_lseq++;
        chk("R5 room after one", int'(req_valid), 1);
        step();
        exp_lseq++;
        chk("R5 full", int'(req_valid), 0);
        chk("R4 second advance", int'(req_addr), 12'h140);
        step();
        chk("R5 still full", int'(req_valid), 0);
        chk("R5 no issue", int'(req_lseq), exp_lseq & 255);
        req_ready = 1'b0;
        rsp_valid = 1'b1;
        step();
        chk("R5 freed", int'(req_valid), 1);
        step();
        rsp_valid = 1'b0;

        // R6: redirect wins over a matching prediction
        redir_valid = 1'b1; redir_pc = 12'h200; redir_stream = 8'h21; redir_pred = 8'h07;
        pred_valid = 1'b1; pred_pc = 12'h300; pred_stream = 8'h20; pred_pred = 8'h09;
        step();
        redir_valid = 1'b0; pred_valid = 1'b0;
        chk("R6 addr", int'(req_addr), 12'h200);
        chk("R6 stream", int'(req_stream), 8'h21);
        chk("R6 pred", int'(req_pred), 8'h07);

        // R7: matching prediction accepted
        pred_valid = 1'b1; pred_pc = 12'h345; pred_stream = 8'h21; pred_pred = 8'h0A;
        step();
        pred_valid = 1'b0;
        chk("R7 accept addr", int'(req_addr), 12'h344);
        chk("R7 accept pred", int'(req_pred), 8'h0A);
        chk("R7 accept stream", int'(req_stream), 8'h21);

        // R7: stale-stream prediction dropped
        pred_valid = 1'b1; pred_pc = 12'h400; pred_stream = 8'h20; pred_pred = 8'h0B;
        step();
        pred_valid = 1'b0;
        chk("R7 drop addr", int'(req_addr), 12'h344);
        chk("R7 drop pred", int'(req_pred), 8'h0A);

        // R8: halt ignores steering and blocks issue
        halt = 1'b1;
        redir_valid = 1'b1; redir_pc = 12'h500; redir_stream = 8'h30; redir_pred = 8'h01;
        pred_valid = 1'b1; pred_pc = 12'h600; pred_stream = 8'h21; pred_pred = 8'h02;
        req_ready = 1'b1;
        step();
        chk("R8 no valid", int'(req_valid), 0);
        chk("R8 no issue", int'(req_lseq), exp_lseq & 255);
        halt = 1'b0; redir_valid = 1'b0; pred_valid = 1'b0; req_ready = 1'b0;
        step();
        chk("R8 resume", int'(req_valid), 1);
        chk("R8 addr kept", int'(req_addr), 12'h344);
        chk("R8 stream kept", int'(req_stream), 8'h21);
        chk("R8 pred kept", int'(req_pred), 8'h0A);

        // R9: faulting completion stops issue until a redirect
        req_ready = 1'b1;
        step();
        req_ready = 1'b0;
        exp_lseq++;
        chk("R4 offset advance", int'(req_addr), 12'h360);
        rsp_valid = 1'b1; rsp_fault = 1'b1;
        step();
        rsp_valid = 1'b0; rsp_fault = 1'b0;
        chk("R9 stopped", int'(req_valid), 0);
        step();
        chk("R9 stays stopped", int'(req_valid), 0);
        redir_valid = 1'b1; redir_pc = 12'h700; redir_stream = 8'h40; redir_pred = 8'h00;
        step();
        redir_valid = 1'b0;
        chk("R9 restart", int'(req_valid), 1);
        chk("R9 restart addr", int'(req_addr), 12'h700);
        chk("R10 final lseq", int'(req_lseq), exp_lseq & 255);

        done = 1'b1;
        finish_run();
    end
endmodule